// File: doc/BRIEF.md
# Indirect-Access Interrupt Redirection Controller

This block routes up to 24 interrupt input pins to delivery requests. Each pin has a 64-bit routing entry that chooses the vector, destination, delivery mode, destination mode, polarity, edge or level sensing and a mask. Software never addresses these entries directly. It writes a register number into an index register and then reads or writes the selected 32-bit word through a data window. The same window also reaches a unit ID register, a read-only version register and an arbitration register.

Each pin is registered, turned into an active-level signal using its polarity bit, and then sensed as an edge or a level. An unmasked pin with a request becomes a candidate. A small two-state delivery machine takes the lowest-numbered candidate and offers it on a request/acknowledge handshake. In state `ST_IDLE` it waits for any candidate. When one exists, it captures the winner's pin, vector and destination and moves to `ST_OFFER` (transition *capture*). In `ST_OFFER` it holds the request until `req_ack` is seen, then returns to `ST_IDLE` (transition *accept*). Acceptance clears a pending edge, or sets the remote IRR bit of a level entry. Remote IRR stays set until an end-of-interrupt carrying the entry's vector arrives.

Top module: `intr_redirect`

## Requirements
- R1: Bus address 0 is the index register, which holds bits 7:0 of the last value written there and reads back as `{24'h0, index}`. Bus address 1 is the data window onto the register selected by the index.
- R2: Index 0x00 is the unit ID register. The ID is 4 bits in bits 27:24 and is writable. All other bits read zero, and the ID resets to 0.
- R3: Index 0x01 is read-only and returns `{8'h00, PINS-1, 8'h00, VERSION}`, which is 0x00170020 with the defaults.
- R4: When VERSION is 0x10 or higher, index 0x02 is a 4-bit writable arbitration value in bits 27:24, with all other bits zero.
- R5: The entry for pin n is at index 0x10+2n (low word) and 0x11+2n (high word). The low word is laid out as follows: vector 7:0, delivery mode 10:8, destination mode 11, delivery status 12 (read-only), polarity 13 (1 = active low), remote IRR 14 (read-only), trigger 15 (1 = level), mask 16. The high word holds the destination in bits 31:24. Writes to the read-only bits and the reserved bits have no effect.
- R6: After reset every low word reads 0x00010000 (masked) and every high word reads 0.
- R7: An index that maps to no register reads zero, and writing it changes no register.
- R8: In edge mode, an unmasked pin raises one request for each transition to its active level. Holding the level does not repeat the request, and a masked pin raises none.
- R9: In level mode, an unmasked pin requests while it is at its active level and remote IRR is 0. Acceptance sets remote IRR, which stops further requests.
- R10: A cycle with `eoi_valid` high clears remote IRR in every level-mode entry whose vector equals `eoi_vector`. Entries with other vectors keep it.
- R11: Simultaneous candidates are offered lowest pin first, one per acknowledge.
- R12: While `req_valid` is high and `req_ack` is low, `req_valid`, `req_vector` and `req_dest` hold. The cycle after an acknowledge, `req_valid` is low.
- R13: Delivery status reads 1 from the moment a request is raised until it is accepted, and 0 afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe for the register bus |
| bus_addr | input | 1 | 0 selects the index register, 1 selects the data window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the addressed register (combinational) |
| irq_in | input | PINS | Interrupt input pins |
| req_valid | output | 1 | Delivery request offered |
| req_vector | output | 8 | Vector of the offered request |
| req_dest | output | 8 | Destination of the offered request |
| req_ack | input | 1 | Acknowledges the offered request |
| eoi_valid | input | 1 | End-of-interrupt strobe |
| eoi_vector | input | 8 | Vector carried by the end-of-interrupt |

## Verification
A wrong pending or remote IRR bit shows up at the ports in two ways. The handshake either gains a request or loses one within a few cycles of the pin change, the acknowledge or the end-of-interrupt. The delivery status and remote IRR bits read back through the window also show it at once. A broken priority encoder or a corrupted capture register shows up on the next offer, as a vector or destination that differs from the queued expectation. A decode fault in the index path shows up on the first read-back that follows the write.

// File: rtl/intr_redirect_pkg.sv
`timescale 1ns/1ps
package intr_redirect_pkg;
    localparam int IDX_W  = 8;
    localparam int VEC_W  = 8;
    localparam int DEST_W = 8;

    localparam logic [IDX_W-1:0] IDX_UNIT_ID  = 8'h00;
    localparam logic [IDX_W-1:0] IDX_VERSION  = 8'h01;
    localparam logic [IDX_W-1:0] IDX_ARBITER  = 8'h02;
    localparam logic [IDX_W-1:0] IDX_TBL_BASE = 8'h10;

    // one routing entry as stored (read-only status bits live elsewhere)
    typedef struct packed {
        logic [DEST_W-1:0] dest;
        logic              mask;
        logic              level;
        logic              act_low;
        logic              logical;
        logic [2:0]        dmode;
        logic [VEC_W-1:0]  vec;
    } route_t;

    localparam route_t ROUTE_RESET = '{dest: '0, mask: 1'b1, level: 1'b0,
                                       act_low: 1'b0, logical: 1'b0,
                                       dmode: 3'h0, vec: '0};

    typedef enum logic [0:0] {
        ST_IDLE  = 1'b0,
        ST_OFFER = 1'b1
    } offer_state_e;
endpackage

// File: rtl/iru_regfile.sv
`timescale 1ns/1ps
module iru_regfile
    import intr_redirect_pkg::*;
#(
    parameter int          PINS    = 24,
    parameter logic [7:0]  VERSION = 8'h20
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_wr,
    input  logic                 bus_addr,
    input  logic [31:0]          bus_wdata,
    output logic [31:0]          bus_rdata,
    input  logic [PINS-1:0]      stat_pend,
    input  logic [PINS-1:0]      stat_rirr,
    output logic [IDX_W-1:0]     idx_o,
    output logic [PINS-1:0]      mask_o,
    output logic [PINS-1:0]      level_o,
    output logic [PINS-1:0]      act_low_o,
    output logic [VEC_W-1:0]     vec_o  [PINS],
    output logic [DEST_W-1:0]    dest_o [PINS]
);
    localparam int  SEL_W   = IDX_W - 1;
    localparam int  TBL_END = int'(IDX_TBL_BASE) + 2 * PINS;
    localparam bit  HAS_ARB = (VERSION >= 8'h10);

    logic [IDX_W-1:0] idx_q;
    logic [3:0]       unit_id_q;
    logic [3:0]       arb_q;
    route_t           ent [PINS];

    logic             win_wr;
    logic             tbl_hit;
    logic [IDX_W-1:0] tbl_off;
    logic [SEL_W-1:0] pin_sel;
    logic             word_hi;
    logic             wdata_unused;

    assign win_wr  = bus_wr && bus_addr;
    assign tbl_hit = (idx_q >= IDX_TBL_BASE) && ({1'b0, idx_q} < 9'(TBL_END));
    assign tbl_off = idx_q - IDX_TBL_BASE;
    assign pin_sel = tbl_off[IDX_W-1:1];
    assign word_hi = tbl_off[0];
    assign idx_o   = idx_q;
    assign wdata_unused = ^{bus_wdata[23:17], bus_wdata[14], bus_wdata[12]};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q <= '0;
        end else if (bus_wr && !bus_addr) begin
            idx_q <= bus_wdata[IDX_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            unit_id_q <= '0;
        end else if (win_wr && idx_q == IDX_UNIT_ID) begin
            unit_id_q <= bus_wdata[27:24];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            arb_q <= '0;
        end else if (HAS_ARB && win_wr && idx_q == IDX_ARBITER) begin
            arb_q <= bus_wdata[27:24];
        end
    end

    for (genvar gi = 0; gi < PINS; gi++) begin : g_entry
        route_t ent_q;
        logic   hit;

        assign hit = win_wr && tbl_hit && (pin_sel == SEL_W'(gi));

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ent_q <= ROUTE_RESET;
            end else if (hit && word_hi) begin
                ent_q.dest <= bus_wdata[31:24];
            end else if (hit) begin
                ent_q.vec     <= bus_wdata[7:0];
                ent_q.dmode   <= bus_wdata[10:8];
                ent_q.logical <= bus_wdata[11];
                ent_q.act_low <= bus_wdata[13];
                ent_q.level   <= bus_wdata[15];
                ent_q.mask    <= bus_wdata[16];
            end
        end

        assign ent[gi]       = ent_q;
        assign mask_o[gi]    = ent_q.mask;
        assign level_o[gi]   = ent_q.level;
        assign act_low_o[gi] = ent_q.act_low;
        assign vec_o[gi]     = ent_q.vec;
        assign dest_o[gi]    = ent_q.dest;
    end

    route_t sel_ent;
    logic   sel_pend;
    logic   sel_rirr;

    always_comb begin
        sel_ent  = ROUTE_RESET;
        sel_pend = 1'b0;
        sel_rirr = 1'b0;
        for (int i = 0; i < PINS; i++) begin
            if (pin_sel == SEL_W'(i)) begin
                sel_ent  = ent[i];
                sel_pend = stat_pend[i];
                sel_rirr = stat_rirr[i];
            end
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (!bus_addr) begin
            bus_rdata[IDX_W-1:0] = idx_q;
        end else if (idx_q == IDX_UNIT_ID) begin
            bus_rdata[27:24] = unit_id_q;
        end else if (idx_q == IDX_VERSION) begin
            bus_rdata = {8'h00, 8'(PINS - 1), 8'h00, VERSION};
        end else if (HAS_ARB && idx_q == IDX_ARBITER) begin
            bus_rdata[27:24] = arb_q;
        end else if (tbl_hit && word_hi) begin
            bus_rdata[31:24] = sel_ent.dest;
        end else if (tbl_hit) begin
            bus_rdata[7:0]  = sel_ent.vec;
            bus_rdata[10:8] = sel_ent.dmode;
            bus_rdata[11]   = sel_ent.logical;
            bus_rdata[12]   = sel_pend;
            bus_rdata[13]   = sel_ent.act_low;
            bus_rdata[14]   = sel_rirr;
            bus_rdata[15]   = sel_ent.level;
            bus_rdata[16]   = sel_ent.mask;
        end
    end
endmodule

// File: rtl/iru_pin_sense.sv
`timescale 1ns/1ps
module iru_pin_sense
    import intr_redirect_pkg::*;
#(
    parameter int PINS  = 24,
    parameter int PIN_W = $clog2(PINS)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [PINS-1:0]    irq_in,
    input  logic [PINS-1:0]    mask_i,
    input  logic [PINS-1:0]    level_i,
    input  logic [PINS-1:0]    act_low_i,
    input  logic [VEC_W-1:0]   vec_i [PINS],
    input  logic               grant_v,
    input  logic [PIN_W-1:0]   grant_pin,
    input  logic               eoi_valid,
    input  logic [VEC_W-1:0]   eoi_vector,
    output logic [PINS-1:0]    cand_o,
    output logic [PINS-1:0]    pend_o,
    output logic [PINS-1:0]    rirr_o
);
    logic [PINS-1:0] pin_q;
    logic [PINS-1:0] pin_p;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pin_q <= '0;
            pin_p <= '0;
        end else begin
            pin_q <= irq_in;
            pin_p <= pin_q;
        end
    end

    for (genvar gi = 0; gi < PINS; gi++) begin : g_pin
        logic act_now;
        logic act_prev;
        logic edge_hit;
        logic won;
        logic edge_pend_q;
        logic rirr_q;

        assign act_now  = pin_q[gi] ^ act_low_i[gi];
        assign act_prev = pin_p[gi] ^ act_low_i[gi];
        assign edge_hit = act_now && !act_prev && !mask_i[gi] && !level_i[gi];
        assign won      = grant_v && (grant_pin == PIN_W'(gi));

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                edge_pend_q <= 1'b0;
            end else if (edge_hit) begin
                edge_pend_q <= 1'b1;
            end else if (won) begin
                edge_pend_q <= 1'b0;
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                rirr_q <= 1'b0;
            end else if (won && level_i[gi]) begin
                rirr_q <= 1'b1;
            end else if (eoi_valid && level_i[gi] && eoi_vector == vec_i[gi]) begin
                rirr_q <= 1'b0;
            end
        end

        assign cand_o[gi] = !mask_i[gi] &&
                            (level_i[gi] ? (act_now && !rirr_q) : edge_pend_q);
        assign pend_o[gi] = level_i[gi] ? (!mask_i[gi] && act_now && !rirr_q)
                                        : edge_pend_q;
        assign rirr_o[gi] = rirr_q;
    end
endmodule

// File: rtl/iru_deliver.sv
`timescale 1ns/1ps
module iru_deliver
    import intr_redirect_pkg::*;
#(
    parameter int PINS  = 24,
    parameter int PIN_W = $clog2(PINS)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [PINS-1:0]    cand_i,
    input  logic [VEC_W-1:0]   vec_i  [PINS],
    input  logic [DEST_W-1:0]  dest_i [PINS],
    input  logic               req_ack,
    output logic               req_valid,
    output logic [VEC_W-1:0]   req_vector,
    output logic [DEST_W-1:0]  req_dest,
    output logic               grant_v,
    output logic [PIN_W-1:0]   grant_pin
);
    offer_state_e      state_q, state_d;
    logic [PIN_W-1:0]  pin_q;
    logic [VEC_W-1:0]  vec_q;
    logic [DEST_W-1:0] dest_q;

    logic              win_found;
    logic [PIN_W-1:0]  win_pin;
    logic [VEC_W-1:0]  win_vec;
    logic [DEST_W-1:0] win_dest;

    // lowest pin number wins
    always_comb begin
        win_found = 1'b0;
        win_pin   = '0;
        win_vec   = '0;
        win_dest  = '0;
        for (int i = PINS - 1; i >= 0; i--) begin
            if (cand_i[i]) begin
                win_found = 1'b1;
                win_pin   = PIN_W'(i);
                win_vec   = vec_i[i];
                win_dest  = dest_i[i];
            end
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (win_found) state_d = ST_OFFER;
            ST_OFFER: if (req_ack)   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pin_q  <= '0;
            vec_q  <= '0;
            dest_q <= '0;
        end else if (state_q == ST_IDLE && win_found) begin
            pin_q  <= win_pin;
            vec_q  <= win_vec;
            dest_q <= win_dest;
        end
    end

    always_comb begin
        req_valid  = (state_q == ST_OFFER);
        req_vector = vec_q;
        req_dest   = dest_q;
        grant_v    = (state_q == ST_OFFER) && req_ack;
        grant_pin  = pin_q;
    end
endmodule

// File: rtl/intr_redirect.sv
`timescale 1ns/1ps
module intr_redirect
    import intr_redirect_pkg::*;
#(
    parameter int          PINS    = 24,
    parameter logic [7:0]  VERSION = 8'h20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_wr,
    input  logic             bus_addr,
    input  logic [31:0]      bus_wdata,
    output logic [31:0]      bus_rdata,
    input  logic [PINS-1:0]  irq_in,
    output logic             req_valid,
    output logic [7:0]       req_vector,
    output logic [7:0]       req_dest,
    input  logic             req_ack,
    input  logic             eoi_valid,
    input  logic [7:0]       eoi_vector
);
    localparam int PIN_W = $clog2(PINS);

    logic [IDX_W-1:0]  index_q;
    logic [PINS-1:0]   mask_v, level_v, act_low_v;
    logic [VEC_W-1:0]  vec_v  [PINS];
    logic [DEST_W-1:0] dest_v [PINS];
    logic [PINS-1:0]   cand, pend, rirr;
    logic              grant_v;
    logic [PIN_W-1:0]  grant_pin;

    iru_regfile #(.PINS(PINS), .VERSION(VERSION)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .stat_pend (pend),
        .stat_rirr (rirr),
        .idx_o     (index_q),
        .mask_o    (mask_v),
        .level_o   (level_v),
        .act_low_o (act_low_v),
        .vec_o     (vec_v),
        .dest_o    (dest_v)
    );

    iru_pin_sense #(.PINS(PINS), .PIN_W(PIN_W)) u_sense (
        .clk        (clk),
        .rst_n      (rst_n),
        .irq_in     (irq_in),
        .mask_i     (mask_v),
        .level_i    (level_v),
        .act_low_i  (act_low_v),
        .vec_i      (vec_v),
        .grant_v    (grant_v),
        .grant_pin  (grant_pin),
        .eoi_valid  (eoi_valid),
        .eoi_vector (eoi_vector),
        .cand_o     (cand),
        .pend_o     (pend),
        .rirr_o     (rirr)
    );

    iru_deliver #(.PINS(PINS), .PIN_W(PIN_W)) u_dlv (
        .clk        (clk),
        .rst_n      (rst_n),
        .cand_i     (cand),
        .vec_i      (vec_v),
        .dest_i     (dest_v),
        .req_ack    (req_ack),
        .req_valid  (req_valid),
        .req_vector (req_vector),
        .req_dest   (req_dest),
        .grant_v    (grant_v),
        .grant_pin  (grant_pin)
    );
endmodule

// File: rtl/intr_redirect_chk.sv
`timescale 1ns/1ps
module intr_redirect_chk #(
    parameter int          PINS    = 24,
    parameter logic [7:0]  VERSION = 8'h20
) (
    input logic            clk,
    input logic            rst_n,
    input logic            bus_addr,
    input logic [7:0]      index_q,
    input logic [31:0]     bus_rdata,
    input logic            req_valid,
    input logic            req_ack,
    input logic [7:0]      req_vector,
    input logic [7:0]      req_dest,
    input logic [PINS-1:0] cand
);
    a_r2_id_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr && index_q == 8'h00) |-> (bus_rdata[31:28] == 4'h0 && bus_rdata[23:0] == 24'h0));

    a_r3_version_value: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr && index_q == 8'h01) |-> (bus_rdata == {8'h00, 8'(PINS - 1), 8'h00, VERSION}));

    a_r7_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr && index_q == 8'h03) |-> (bus_rdata == 32'h0));

    a_r12_hold_until_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_ack) |=> (req_valid && $stable(req_vector) && $stable(req_dest)));

    a_r12_drop_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ack) |=> !req_valid);

    a_r11_offer_has_source: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(req_valid) |-> $past(|cand));
endmodule

bind intr_redirect intr_redirect_chk #(.PINS(PINS), .VERSION(VERSION)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_addr   (bus_addr),
    .index_q    (index_q),
    .bus_rdata  (bus_rdata),
    .req_valid  (req_valid),
    .req_ack    (req_ack),
    .req_vector (req_vector),
    .req_dest   (req_dest),
    .cand       (cand)
);

// File: tb/intr_redirect_bench.sv
`timescale 1ns/1ps
module intr_redirect_bench;
    localparam int PINS = 24;

    logic            clk = 1'b0;
    logic            rst_n;
    logic            bus_wr;
    logic            bus_addr;
    logic [31:0]     bus_wdata;
    logic [31:0]     bus_rdata;
    logic [PINS-1:0] irq_in;
    logic            req_valid;
    logic [7:0]      req_vector;
    logic [7:0]      req_dest;
    logic            req_ack;
    logic            eoi_valid;
    logic [7:0]      eoi_vector;

    always #2.5 clk = ~clk;

    intr_redirect #(.PINS(PINS), .VERSION(8'h20)) u_intr_redirect (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_in(irq_in),
        .req_valid(req_valid), .req_vector(req_vector), .req_dest(req_dest),
        .req_ack(req_ack), .eoi_valid(eoi_valid), .eoi_vector(eoi_vector)
    );

    int          checks = 0;
    int          errors = 0;
    int          got    = 0;
    bit          mon_en = 1'b0;
    logic [15:0] sbq [$];
    string       tagq [$];

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic bus_write(input logic a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic reg_wr(input logic [7:0] idx, input logic [31:0] d);
        bus_write(1'b0, {24'h0, idx});
        bus_write(1'b1, d);
    endtask

    task automatic reg_rd(input logic [7:0] idx, output logic [31:0] d);
        bus_write(1'b0, {24'h0, idx});
        bus_addr = 1'b1;
        #1 d = bus_rdata;
    endtask

    task automatic program_pin(input int pin, input logic [7:0] vec, input logic [7:0] dest,
                               input bit act_low, input bit level, input bit mask);
        reg_wr(8'(8'h11 + 2 * pin), {dest, 24'h0});
        reg_wr(8'(8'h10 + 2 * pin), {15'h0, mask, level, 1'b0, act_low, 1'b0, 1'b0, 3'b000, vec});
    endtask

    task automatic expect_req(input logic [7:0] vec, input logic [7:0] dest, input string tag);
        sbq.push_back({vec, dest});
        tagq.push_back(tag);
    endtask

    task automatic drain(input int n, input string tag);
        repeat (n) @(negedge clk);
        check(sbq.size() == 0, tag, "expected requests still outstanding",
              32'(sbq.size()), 32'h0);
    endtask

    task automatic send_eoi(input logic [7:0] v);
        @(negedge clk);
        eoi_valid = 1'b1; eoi_vector = v;
        @(negedge clk);
        eoi_valid = 1'b0;
    endtask

    // monitor: pops the scoreboard and acknowledges each offer
    initial begin
        logic [15:0] e;
        string       t;
        forever begin
            @(negedge clk);
            if (req_ack) begin
                req_ack = 1'b0;
            end else if (req_valid && mon_en) begin
                got++;
                if (sbq.size() == 0) begin
                    check(1'b0, "R8/R9/R11", "unexpected request", {16'h0, req_vector, req_dest}, 32'h0);
                end else begin
                    e = sbq.pop_front();
                    t = tagq.pop_front();
                    check({req_vector, req_dest} == e, t, "request vector/dest",
                          {16'h0, req_vector, req_dest}, {16'h0, e});
                end
                req_ack = 1'b1;
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [31:0] d;
        int          g;
        rst_n = 1'b0; bus_wr = 1'b0; bus_addr = 1'b0; bus_wdata = '0;
        irq_in = '0; req_ack = 1'b0; eoi_valid = 1'b0; eoi_vector = '0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        mon_en = 1'b1;

        // reset state
        reg_rd(8'h01, d); check(d == 32'h0017_0020, "R3", "version register", d, 32'h0017_0020);
        reg_rd(8'h10, d); check(d == 32'h0001_0000, "R6", "pin0 low word at reset", d, 32'h0001_0000);
        reg_rd(8'h3E, d); check(d == 32'h0001_0000, "R6", "pin23 low word at reset", d, 32'h0001_0000);
        reg_rd(8'h3F, d); check(d == 32'h0, "R6", "pin23 high word at reset", d, 32'h0);
        reg_rd(8'h00, d); check(d == 32'h0, "R2", "unit ID at reset", d, 32'h0);

        // R1 index read back
        bus_write(1'b0, 32'hABCD_EF21);
        bus_addr = 1'b0;
        #1 check(bus_rdata == 32'h21, "R1", "index read back", bus_rdata, 32'h21);

        // R2 unit ID
        reg_wr(8'h00, 32'hFFFF_FFFF);
        reg_rd(8'h00, d); check(d == 32'h0F00_0000, "R2", "ID all-ones write", d, 32'h0F00_0000);
        reg_wr(8'h00, 32'h0500_0000);
        reg_rd(8'h00, d); check(d == 32'h0500_0000, "R2", "ID write 5", d, 32'h0500_0000);

        // R4 arbitration
        reg_wr(8'h02, 32'hFFFF_FFFF);
        reg_rd(8'h02, d); check(d == 32'h0F00_0000, "R4", "arbitration field", d, 32'h0F00_0000);

        // R7 unmapped indices
        reg_wr(8'h40, 32'hFFFF_FFFF);
        reg_rd(8'h40, d); check(d == 32'h0, "R7", "index 0x40 reads zero", d, 32'h0);
        reg_rd(8'h03, d); check(d == 32'h0, "R7", "index 0x03 reads zero", d, 32'h0);
        reg_rd(8'h3F, d); check(d == 32'h0, "R7", "pin23 high untouched", d, 32'h0);
        reg_rd(8'h00, d); check(d == 32'h0500_0000, "R7", "ID untouched", d, 32'h0500_0000);

        // R5 layout and read-only bits
        reg_wr(8'h1A, 32'hFFFF_FFFF);
        reg_rd(8'h1A, d); check(d == 32'h0001_AFFF, "R5", "pin5 low word layout", d, 32'h0001_AFFF);
        reg_wr(8'h1B, 32'hFFFF_FFFF);
        reg_rd(8'h1B, d); check(d == 32'hFF00_0000, "R5", "pin5 high word layout", d, 32'hFF00_0000);
        reg_wr(8'h1A, 32'h0001_0000);
        reg_wr(8'h1B, 32'h0);

        // R8 edge mode, active high
        program_pin(3, 8'h33, 8'h81, 1'b0, 1'b0, 1'b0);
        expect_req(8'h33, 8'h81, "R8");
        irq_in[3] = 1'b1;
        drain(12, "R8");
        irq_in[3] = 1'b0;
        repeat (3) @(negedge clk);
        expect_req(8'h33, 8'h81, "R8");
        irq_in[3] = 1'b1;
        drain(12, "R8");

        // R8 masked pin
        g = got;
        irq_in[4] = 1'b1;
        repeat (10) @(negedge clk);
        check(got == g, "R8", "masked pin requests", 32'(got - g), 32'h0);

        // R8 active low edge
        program_pin(10, 8'hA0, 8'h02, 1'b1, 1'b0, 1'b0);
        irq_in[10] = 1'b1;
        repeat (6) @(negedge clk);
        check(got == g, "R8", "inactive transition of active-low pin", 32'(got - g), 32'h0);
        expect_req(8'hA0, 8'h02, "R8");
        irq_in[10] = 1'b0;
        drain(12, "R8");

        // R11 priority, R12 hold
        program_pin(2, 8'h22, 8'h10, 1'b0, 1'b0, 1'b0);
        program_pin(7, 8'h77, 8'h20, 1'b0, 1'b0, 1'b0);
        program_pin(9, 8'h99, 8'h30, 1'b0, 1'b0, 1'b0);
        mon_en = 1'b0;
        @(negedge clk);
        irq_in[9] = 1'b1; irq_in[7] = 1'b1; irq_in[2] = 1'b1;
        repeat (6) @(negedge clk);
        check(req_valid && req_vector == 8'h22, "R11", "lowest pin offered first",
              {23'h0, req_valid, req_vector}, {23'h0, 1'b1, 8'h22});
        repeat (4) @(negedge clk);
        check(req_valid && req_vector == 8'h22 && req_dest == 8'h10, "R12", "offer held without ack",
              {15'h0, req_valid, req_vector, req_dest}, {15'h0, 1'b1, 8'h22, 8'h10});
        expect_req(8'h22, 8'h10, "R11");
        expect_req(8'h77, 8'h20, "R11");
        expect_req(8'h99, 8'h30, "R11");
        mon_en = 1'b1;
        drain(20, "R11");

        // R13 delivery status
        mon_en = 1'b0;
        irq_in[3] = 1'b0;
        repeat (3) @(negedge clk);
        irq_in[3] = 1'b1;
        repeat (4) @(negedge clk);
        reg_rd(8'h16, d); check(d[12] == 1'b1, "R13", "status while pending", {31'h0, d[12]}, 32'h1);
        expect_req(8'h33, 8'h81, "R13");
        mon_en = 1'b1;
        drain(10, "R13");
        reg_rd(8'h16, d); check(d[12] == 1'b0, "R13", "status after accept", {31'h0, d[12]}, 32'h0);

        // R9 / R10 level mode
        program_pin(12, 8'h55, 8'h0C, 1'b0, 1'b1, 1'b0);
        expect_req(8'h55, 8'h0C, "R9");
        irq_in[12] = 1'b1;
        drain(12, "R9");
        reg_rd(8'h28, d); check(d[14] == 1'b1, "R9", "remote IRR after accept", {31'h0, d[14]}, 32'h1);
        g = got;
        send_eoi(8'h56);
        repeat (8) @(negedge clk);
        check(got == g, "R10", "non-matching EOI re-delivers", 32'(got - g), 32'h0);
        reg_rd(8'h28, d); check(d[14] == 1'b1, "R10", "remote IRR kept on other vector", {31'h0, d[14]}, 32'h1);
        expect_req(8'h55, 8'h0C, "R10");
        send_eoi(8'h55);
        drain(12, "R10");
        irq_in[12] = 1'b0;
        repeat (3) @(negedge clk);
        g = got;
        send_eoi(8'h55);
        repeat (8) @(negedge clk);
        check(got == g, "R9", "inactive level pin requests", 32'(got - g), 32'h0);
        reg_rd(8'h28, d); check(d[14] == 1'b0, "R10", "remote IRR cleared by EOI", {31'h0, d[14]}, 32'h0);

        repeat (4) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule